// File: doc/BRIEF.md
# Single-Vector Interrupt Injection Unit

This block sits in the opcode-fetch path of a small 8-bit-class processor and turns a maskable, active-low interrupt request into a single-vector entry. The request is looked at only on the cycle that closes an instruction. If it is active then and interrupts are enabled, the next opcode fetch is hijacked. Memory is not read and the program counter does not advance. The decoder is handed a fixed one-byte restart opcode instead of the byte on the bus. That opcode acts as a call to address 0x0038: the existing call datapath pushes the unchanged PC and jumps.

Taking an interrupt masks further interrupts. The enable-interrupts instruction unmasks them only after a shadow of one instruction, by default. This lets the return instruction that usually follows it finish before a still-active request is taken again. The request is level-sensitive and is never latched. A request that goes away before an instruction boundary leaves no trace. A request that is still held after the handler returns is simply seen again at the next boundary.

Top module: `irq_inject_unit`

## Requirements
- R1: After reset the enable flag reads 0. No substitution takes place: a fetch passes the memory byte through with both the read enable and the PC-increment enable high.
- R2: On a normal fetch (fetch_req high, nothing pending), opcode_out equals mem_byte, and mem_rd_en and pc_inc_en are both 1. When fetch_req is low, mem_rd_en, pc_inc_en and int_ack are all 0.
- R3: The request is sampled only in a cycle with instr_end high. A request that is active between boundaries and released before the next boundary causes no substitution.
- R4: If the request (irq_n = 0) is seen at a boundary while the enable flag is 1 and no shadow is running, the next fetch substitutes the vector opcode. opcode_out = VEC_OPCODE (0xFF by default), mem_rd_en = 0, pc_inc_en = 0, and int_ack = 1 for that one fetch cycle.
- R5: A substituted fetch clears the enable flag. From the next cycle on, int_en reads 0 and later requests are ignored.
- R6: While the enable flag is 0, an active request at a boundary causes no substitution.
- R7: An ei_strobe raised on an instruction's boundary cycle sets the enable flag from the next cycle on. The request is then ignored at the boundaries of the next SHADOW_INSTRS instructions (default 1) and is taken at the boundary after them.
- R8: A di_strobe raised on a boundary cycle clears the enable flag from the next cycle on. No request is taken at that boundary. When ei_strobe and di_strobe are both high, disable wins.
- R9: An accepted request is substituted at the first fetch after its boundary, however many non-fetch cycles come between them. It is substituted exactly once: the following fetch passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Maskable interrupt request, active low, level-sensitive |
| instr_end | input | 1 | High on the last cycle of each instruction |
| ei_strobe | input | 1 | Enable-interrupts instruction, raised on its boundary cycle |
| di_strobe | input | 1 | Disable-interrupts instruction, raised on its boundary cycle |
| fetch_req | input | 1 | Opcode fetch cycle requested by the sequencer |
| mem_byte | input | DATA_W | Byte read from memory for the fetch |
| opcode_out | output | DATA_W | Opcode handed to the decoder |
| mem_rd_en | output | 1 | Memory read enable for the fetch |
| pc_inc_en | output | 1 | Program-counter increment enable |
| int_ack | output | 1 | One-cycle strobe on a substituted fetch |
| int_en | output | 1 | Current interrupt enable flag |

## Verification
The bench builds the unit with its defaults: 8-bit opcodes, the 0xFF restart opcode, a one-instruction shadow and a two-stage request synchroniser. This makes it hold the request steady for three cycles before each boundary it tests. That setting brings within reach the shadow being used up instruction by instruction, and the case where a request is held but withdrawn before a boundary. It also covers substitution delayed past idle cycles and the enable/disable collision on a single boundary.

// File: rtl/irq_inj_pkg.sv
package irq_inj_pkg;
   // Source selected for the opcode handed to the decoder
   typedef enum logic {
      SRC_MEMORY = 1'b0,
      SRC_VECTOR = 1'b1
   } fetch_src_e;
endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n,
   output logic req_active
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("irq_req_sync: STAGES must lie in 0..4");
      end
      if (STAGES == 0) begin : g_direct
         assign req_active = ~req_n;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2+((STAGES==1)?1:0):0], req_n} ;
         end
         assign req_active = ~chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate #(
   parameter int SHADOW_INSTRS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_active,
   input  logic instr_end,
   input  logic ei_strobe,
   input  logic di_strobe,
   input  logic inject,
   output logic ie_q,
   output logic pending_q
);
   localparam int CNT_W = $clog2(SHADOW_INSTRS + 1);

   generate
      if (SHADOW_INSTRS < 1) begin : g_bad
         $error("irq_accept_gate: SHADOW_INSTRS must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] shadow_q;
   logic             shadow_idle;
   logic             take;

   assign shadow_idle = (shadow_q == '0);
   assign take = instr_end && !ei_strobe && !di_strobe && ie_q && shadow_idle && req_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q      <= 1'b0;
         shadow_q  <= '0;
         pending_q <= 1'b0;
      end else begin
         if (di_strobe)        ie_q <= 1'b0;
         else if (ei_strobe)   ie_q <= 1'b1;
         else if (inject)      ie_q <= 1'b0;

         if (ei_strobe && !di_strobe)
            shadow_q <= CNT_W'(SHADOW_INSTRS);
         else if (di_strobe)
            shadow_q <= '0;
         else if (instr_end && !shadow_idle)
            shadow_q <= shadow_q - 1'b1;

         if (take)        pending_q <= 1'b1;
         else if (inject) pending_q <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_fetch_mux.sv
module irq_fetch_mux
   import irq_inj_pkg::*;
#(
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] VEC_OPCODE = '1
) (
   input  logic              fetch_req,
   input  logic              pending,
   input  logic [DATA_W-1:0] mem_byte,
   output logic [DATA_W-1:0] opcode_out,
   output logic              mem_rd_en,
   output logic              pc_inc_en,
   output logic              inject
);
   fetch_src_e src;

   always_comb begin
      src        = (fetch_req && pending) ? SRC_VECTOR : SRC_MEMORY;
      inject     = (src == SRC_VECTOR);
      mem_rd_en  = fetch_req && (src == SRC_MEMORY);
      pc_inc_en  = fetch_req && (src == SRC_MEMORY);
      opcode_out = (src == SRC_VECTOR) ? VEC_OPCODE : mem_byte;
   end
endmodule

// File: rtl/irq_inject_unit.sv
module irq_inject_unit #(
   parameter int                DATA_W        = 8,
   parameter logic [DATA_W-1:0] VEC_OPCODE    = '1,
   parameter int                SHADOW_INSTRS = 1,
   parameter int                SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_n,
   input  logic              instr_end,
   input  logic              ei_strobe,
   input  logic              di_strobe,
   input  logic              fetch_req,
   input  logic [DATA_W-1:0] mem_byte,
   output logic [DATA_W-1:0] opcode_out,
   output logic              mem_rd_en,
   output logic              pc_inc_en,
   output logic              int_ack,
   output logic              int_en
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("irq_inject_unit: DATA_W must be positive");
      end
   endgenerate

   logic req_active;
   logic pending;
   logic inject;

   irq_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_n      (irq_n),
      .req_active (req_active)
   );

   irq_accept_gate #(.SHADOW_INSTRS(SHADOW_INSTRS)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_active (req_active),
      .instr_end  (instr_end),
      .ei_strobe  (ei_strobe),
      .di_strobe  (di_strobe),
      .inject     (inject),
      .ie_q       (int_en),
      .pending_q  (pending)
   );

   irq_fetch_mux #(.DATA_W(DATA_W), .VEC_OPCODE(VEC_OPCODE)) u_mux (
      .fetch_req  (fetch_req),
      .pending    (pending),
      .mem_byte   (mem_byte),
      .opcode_out (opcode_out),
      .mem_rd_en  (mem_rd_en),
      .pc_inc_en  (pc_inc_en),
      .inject     (inject)
   );

   assign int_ack = inject;
endmodule

// File: rtl/irq_inject_chk.sv
module irq_inject_chk #(
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] VEC_OPCODE = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_end,
   input logic              ei_strobe,
   input logic              di_strobe,
   input logic              fetch_req,
   input logic [DATA_W-1:0] mem_byte,
   input logic [DATA_W-1:0] opcode_out,
   input logic              mem_rd_en,
   input logic              pc_inc_en,
   input logic              int_ack,
   input logic              int_en
);
   // R2: no fetch, no memory or PC activity
   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_req |-> (!mem_rd_en && !pc_inc_en && !int_ack));

   // R2: a plain fetch passes the memory byte through
   assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !int_ack) |-> (mem_rd_en && pc_inc_en && opcode_out == mem_byte));

   // R4: a substituted fetch carries the vector and suppresses read and increment
   assert_vector_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |-> (opcode_out == VEC_OPCODE && !mem_rd_en && !pc_inc_en));

   // R4: acknowledge only on an enabled fetch
   assert_ack_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |-> int_en);

   // R5: taking the vector masks further requests
   assert_ack_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && !ei_strobe) |=> !int_en);

   // R9: a single substitution per acceptance
   assert_single_inject_R9: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |=> !int_ack);

   // R7: enable strobe sets the flag
   assert_ei_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ei_strobe && !di_strobe) |=> int_en);

   // R8: disable strobe clears the flag, winning over enable
   assert_di_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      di_strobe |=> !int_en);

   // R7: the enable boundary itself never queues a vector for the next fetch
   assert_no_take_on_ei_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ei_strobe && instr_end && !int_en) |=> !int_ack);
endmodule

bind irq_inject_unit irq_inject_chk #(.DATA_W(DATA_W), .VEC_OPCODE(VEC_OPCODE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .instr_end  (instr_end),
   .ei_strobe  (ei_strobe),
   .di_strobe  (di_strobe),
   .fetch_req  (fetch_req),
   .mem_byte   (mem_byte),
   .opcode_out (opcode_out),
   .mem_rd_en  (mem_rd_en),
   .pc_inc_en  (pc_inc_en),
   .int_ack    (int_ack),
   .int_en     (int_en)
);

// File: tb/sim_irq_inject_unit.sv
`timescale 1ns/1ps
module sim_irq_inject_unit;
   localparam int         DW  = 8;
   localparam logic [7:0] VEC = 8'hFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          irq_n = 1'b1;
   logic          instr_end = 1'b0;
   logic          ei_strobe = 1'b0;
   logic          di_strobe = 1'b0;
   logic          fetch_req = 1'b0;
   logic [DW-1:0] mem_byte = '0;
   logic [DW-1:0] opcode_out;
   logic          mem_rd_en, pc_inc_en, int_ack, int_en;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   irq_inject_unit u0 (
      .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .instr_end(instr_end),
      .ei_strobe(ei_strobe), .di_strobe(di_strobe), .fetch_req(fetch_req),
      .mem_byte(mem_byte), .opcode_out(opcode_out), .mem_rd_en(mem_rd_en),
      .pc_inc_en(pc_inc_en), .int_ack(int_ack), .int_en(int_en)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // boundary cycle with optional strobes
   task automatic boundary(input bit ei, input bit di);
      @(negedge clk);
      instr_end = 1'b1; ei_strobe = ei; di_strobe = di;
      @(negedge clk);
      instr_end = 1'b0; ei_strobe = 1'b0; di_strobe = 1'b0;
   endtask

   // hold request level long enough to cross the synchroniser
   task automatic set_irq(input bit active);
      @(negedge clk);
      irq_n = ~active;
      idle(3);
   endtask

   // one fetch cycle; checks either pass-through or substitution
   task automatic fetch_expect(input bit vec, input logic [7:0] b, input string req);
      @(negedge clk);
      fetch_req = 1'b1; mem_byte = b;
      #1;
      if (vec) begin
         check(opcode_out == VEC, req, "vector opcode", opcode_out, VEC);
         check(!mem_rd_en && !pc_inc_en, req, "read/inc suppressed", {mem_rd_en, pc_inc_en}, 0);
         check(int_ack == 1'b1, req, "ack", int_ack, 1);
      end else begin
         check(opcode_out == b, req, "pass-through opcode", opcode_out, b);
         check(mem_rd_en && pc_inc_en, req, "read/inc on", {mem_rd_en, pc_inc_en}, 3);
         check(int_ack == 1'b0, req, "no ack", int_ack, 0);
      end
      @(negedge clk);
      fetch_req = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      check(int_en == 1'b0, "R1", "enable after reset", int_en, 0);
      check(!mem_rd_en && !pc_inc_en && !int_ack, "R2", "idle outputs quiet",
            {mem_rd_en, pc_inc_en, int_ack}, 0);
      set_irq(1'b1);
      boundary(1'b0, 1'b0);
      fetch_expect(1'b0, 8'h3C, "R1");
      set_irq(1'b0);
   endtask

   task automatic t_passthrough;
      fetch_expect(1'b0, 8'hA5, "R2");
      fetch_expect(1'b0, 8'h00, "R2");
   endtask

   task automatic t_disabled;
      set_irq(1'b1);
      boundary(1'b0, 1'b0);
      fetch_expect(1'b0, 8'h12, "R6");
      set_irq(1'b0);
   endtask

   task automatic t_shadow_and_take;
      boundary(1'b1, 1'b0);   // enable-interrupts instruction
      #1 check(int_en == 1'b1, "R7", "enable set", int_en, 1);
      set_irq(1'b1);
      boundary(1'b0, 1'b0);   // shadowed instruction (e.g. return)
      fetch_expect(1'b0, 8'hC9, "R7");
      boundary(1'b0, 1'b0);   // request now taken
      fetch_expect(1'b1, 8'h77, "R4");
      #1 check(int_en == 1'b0, "R5", "enable cleared by ack", int_en, 0);
      boundary(1'b0, 1'b0);   // still requesting, now masked
      fetch_expect(1'b0, 8'h34, "R5");
      set_irq(1'b0);
   endtask

   task automatic t_between_boundaries;
      boundary(1'b1, 1'b0);
      boundary(1'b0, 1'b0);   // consume shadow
      set_irq(1'b1);
      set_irq(1'b0);          // withdrawn before boundary
      boundary(1'b0, 1'b0);
      fetch_expect(1'b0, 8'h56, "R3");
      #1 check(int_en == 1'b1, "R3", "enable untouched", int_en, 1);
   endtask

   task automatic t_deferred;
      set_irq(1'b1);
      boundary(1'b0, 1'b0);   // enabled, shadow gone: accepted
      set_irq(1'b0);
      idle(5);
      fetch_expect(1'b1, 8'h9A, "R9");
      fetch_expect(1'b0, 8'h9B, "R9");
   endtask

   task automatic t_disable;
      boundary(1'b1, 1'b0);
      boundary(1'b0, 1'b0);
      set_irq(1'b1);
      boundary(1'b0, 1'b1);   // DI on boundary with request active
      #1 check(int_en == 1'b0, "R8", "DI clears enable", int_en, 0);
      fetch_expect(1'b0, 8'h41, "R8");
      boundary(1'b1, 1'b1);   // both strobes: disable wins
      #1 check(int_en == 1'b0, "R8", "DI beats EI", int_en, 0);
      boundary(1'b0, 1'b0);
      boundary(1'b0, 1'b0);
      fetch_expect(1'b0, 8'h42, "R8");
      set_irq(1'b0);
   endtask

   initial begin
      idle(2);
      rst_n = 1'b1;
      t_reset();
      t_passthrough();
      t_disabled();
      t_shadow_and_take();
      t_between_boundaries();
      t_deferred();
      t_disable();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule